// File: doc/BRIEF.md
# Eight-Lane Double-Rate NAND Frame Generator

This block builds one serial NAND transaction in which every phase uses eight data lines and moves a byte on each edge of the serial clock. A host describes the frame at a start pulse: an opcode, an optional packed second command byte, an address form, a dummy length in byte slots, a data length in bytes and a direction. The block then drives chip select, the serial clock and the eight lines until the frame is finished, and it pulses a completion flag at the end.

Because two bytes cross the bus in every serial clock period, the block works on 16-bit words throughout. The command word repeats the opcode, or carries the top row-address byte in its second half for the packed page read. The address word is either a high/low pair or one register byte sent twice. The dummy phase gives the bus to the device for half as many clocks as there are slots. Write data is pulled from the host one word per clock. Read data is returned one word per clock, with the byte from the rising edge in the upper half. Typical uses are a feature read (0x0F, register byte sent twice, 14 dummy slots, 2 data bytes), a packed page read (0x13 then row bits 23:16, then a 16-bit address pair), and a program load (0xC2 or 0xC4, column pair, then data).

Each serial clock period takes four cycles of the system clock. A byte is launched one system cycle before each serial clock edge and held for one system cycle after it.

Top module: `onand_dtr_frame`

## Requirements
- R1: The first serial clock period of a frame carries the opcode on the rising edge and again on the falling edge, with the lines driven.
- R2: With packing selected, the falling-edge byte of the command period is the supplied packed byte instead of the repeated opcode.
- R3: Address mode 1 sends the address high byte on the rising edge and the low byte on the falling edge. Mode 2 sends the low address byte on both edges. Mode 0 sends no address period.
- R4: The dummy phase lasts dummy_slots/2 serial clock periods with io_oe low, and it sits between the address and the data.
- R5: A write frame sends data_len/2 words, each taken from tx_word, upper byte on the rising edge. tx_take pulses once per word, in the cycle after that word was sampled.
- R6: A read frame returns data_len/2 words on rx_word with one rx_valid pulse each. The upper byte is the byte captured at the rising edge and the lower byte is the byte captured at the falling edge. The lines are released during a read.
- R7: A start with an odd data_len or an odd dummy_slots raises err for one cycle and starts no frame: cs_n stays high and sck does not toggle.
- R8: cs_n is low only while a frame runs, and sck is low whenever cs_n is high. The number of sck edges is twice the number of words in the frame, and done pulses exactly once, together with the rise of cs_n.
- R9: io_out never changes in a cycle in which sck changes.
- R10: A start pulse during a running frame is ignored, and so are changed request inputs: the frame in progress keeps the values captured at its own start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, four cycles per serial clock period |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame; accepted only when idle |
| opcode | input | 8 | Command byte |
| pack_en | input | 1 | Replace the second command byte with pack_byte |
| pack_byte | input | 8 | Packed second command byte |
| addr_mode | input | 2 | 0 none, 1 high/low pair, 2 low byte repeated |
| addr | input | 16 | Address value |
| dummy_slots | input | DUMMY_W | Dummy length in byte slots, must be even |
| data_len | input | LEN_W | Data length in bytes, must be even |
| rd | input | 1 | 1 reads data, 0 writes data |
| tx_word | input | 16 | Next write word, upper byte sent first |
| tx_take | output | 1 | Pulse: current tx_word was consumed |
| rx_word | output | 16 | Read word, rising-edge byte in the upper half |
| rx_valid | output | 1 | Pulse: rx_word is new |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Pulse at the end of a frame |
| err | output | 1 | Pulse: start rejected for an odd length |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| io_out | output | 8 | Eight-line output byte |
| io_oe | output | 1 | Output enable for io_out |
| io_in | input | 8 | Eight-line input byte |

## Verification
The bench sweeps every address form, both command forms, dummy lengths of none, one clock and seven clocks, data lengths from zero to three words, and both directions. It compares every byte seen at an sck edge with a list built from the requirements. A design that dropped the address period or shortened the dummy phase would shift all later bytes and change the edge count. A design that swapped the edge order would return read words with their halves reversed, and a design that took tx_word at the wrong time would send a neighbouring word. Odd lengths must be rejected without any bus activity, and a start issued in the middle of a frame, together with a changed opcode, must leave the frame's command byte and its single done pulse unchanged.

// File: rtl/onand_pkg.sv
package onand_pkg;

  typedef enum logic [1:0] {
    ADR_NONE   = 2'd0,
    ADR_PAIR   = 2'd1,
    ADR_REPEAT = 2'd2
  } onand_addr_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CMD   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_DATA  = 3'd4,
    PH_CLOSE = 3'd5
  } onand_phase_e;

  typedef struct packed {
    logic [7:0]  opcode;
    logic        pack_en;
    logic [7:0]  pack_byte;
    onand_addr_e amode;
    logic [15:0] addr;
    logic        rd;
  } onand_hdr_t;

  // Command word: opcode on the rising edge, then either the opcode again or the packed byte.
  function automatic logic [15:0] cmd_pair(input logic [7:0] op, input logic pk,
                                           input logic [7:0] pb);
    return {op, (pk ? pb : op)};
  endfunction

  // Address word for the two address forms that occupy one clock period.
  function automatic logic [15:0] addr_pair(input onand_addr_e m, input logic [15:0] a);
    logic [15:0] w;
    case (m)
      ADR_PAIR:   w = a;
      ADR_REPEAT: w = {a[7:0], a[7:0]};
      default:    w = 16'h0000;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/onand_dtr_lane.sv
module onand_dtr_lane (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        active,
  input  logic [15:0] word,
  input  logic        word_drive,
  output logic        sck,
  output logic [7:0]  io_out,
  output logic        io_oe,
  output logic        ev_load,
  output logic        ev_rise,
  output logic        ev_fall
);
  localparam int QUARTERS = 4;
  localparam int Q_W = $clog2(QUARTERS);
  localparam logic [Q_W-1:0] Q_LOAD = Q_W'(0);
  localparam logic [Q_W-1:0] Q_RISE = Q_W'(1);
  localparam logic [Q_W-1:0] Q_LOW  = Q_W'(2);
  localparam logic [Q_W-1:0] Q_FALL = Q_W'(3);

  logic [Q_W-1:0] q;
  logic [7:0]     low_hold;

  assign ev_load = active && (q == Q_LOAD);
  assign ev_rise = active && (q == Q_RISE);
  assign ev_fall = active && (q == Q_FALL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q        <= '0;
      sck      <= 1'b0;
      io_out   <= 8'h00;
      io_oe    <= 1'b0;
      low_hold <= 8'h00;
    end else if (!active) begin
      q     <= '0;
      sck   <= 1'b0;
      io_oe <= 1'b0;
    end else begin
      q <= q + Q_W'(1);
      case (q)
        Q_LOAD: begin
          io_out   <= word[15:8];
          low_hold <= word[7:0];
          io_oe    <= word_drive;
        end
        Q_RISE: sck <= 1'b1;
        Q_LOW:  io_out <= low_hold;
        default: sck <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/onand_word_seq.sv
module onand_word_seq
  import onand_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int DUMMY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  onand_hdr_t         hdr_in,
  input  logic [DUMMY_W-1:0] dummy_in,
  input  logic [LEN_W-1:0]   len_in,
  input  logic               step,
  input  logic [15:0]        tx_word,
  output onand_phase_e       phase,
  output logic [15:0]        word,
  output logic               word_drive,
  output logic               word_rx,
  output logic               active,
  output logic               done
);
  localparam int CNT_W = (LEN_W > DUMMY_W) ? LEN_W : DUMMY_W;

  onand_hdr_t         hdr;
  logic [DUMMY_W-1:0] dcyc;
  logic [LEN_W-1:0]   lcyc;
  logic [CNT_W-1:0]   cnt;

  onand_phase_e     nxt_ph;
  logic [CNT_W-1:0] nxt_cnt;
  onand_phase_e     after_cmd, after_addr, after_dummy;

  always_comb begin
    after_dummy = (lcyc != '0) ? PH_DATA : PH_CLOSE;
    after_addr  = (dcyc != '0) ? PH_DUMMY : after_dummy;
    after_cmd   = (hdr.amode != ADR_NONE) ? PH_ADDR : after_addr;
  end

  function automatic logic [CNT_W-1:0] entry_count(input onand_phase_e p,
                                                   input logic [DUMMY_W-1:0] d,
                                                   input logic [LEN_W-1:0] l);
    logic [CNT_W-1:0] c;
    case (p)
      PH_DUMMY: c = CNT_W'(d) - CNT_W'(1);
      PH_DATA:  c = CNT_W'(l) - CNT_W'(1);
      default:  c = '0;
    endcase
    return c;
  endfunction

  always_comb begin
    nxt_ph  = phase;
    nxt_cnt = cnt;
    case (phase)
      PH_IDLE: if (go) nxt_ph = PH_CMD;
      PH_CMD: if (step) begin
        nxt_ph  = after_cmd;
        nxt_cnt = entry_count(after_cmd, dcyc, lcyc);
      end
      PH_ADDR: if (step) begin
        nxt_ph  = after_addr;
        nxt_cnt = entry_count(after_addr, dcyc, lcyc);
      end
      PH_DUMMY: if (step) begin
        if (cnt == '0) begin
          nxt_ph  = after_dummy;
          nxt_cnt = entry_count(after_dummy, dcyc, lcyc);
        end else begin
          nxt_cnt = cnt - CNT_W'(1);
        end
      end
      PH_DATA: if (step) begin
        if (cnt == '0) nxt_ph = PH_CLOSE;
        else nxt_cnt = cnt - CNT_W'(1);
      end
      default: nxt_ph = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      hdr   <= '0;
      dcyc  <= '0;
      lcyc  <= '0;
      done  <= 1'b0;
    end else begin
      phase <= nxt_ph;
      cnt   <= nxt_cnt;
      done  <= (phase == PH_CLOSE);
      if (phase == PH_IDLE && go) begin
        hdr  <= hdr_in;
        dcyc <= dummy_in >> 1;
        lcyc <= len_in >> 1;
      end
    end
  end

  always_comb begin
    word       = 16'h0000;
    word_drive = 1'b0;
    word_rx    = 1'b0;
    case (phase)
      PH_CMD: begin
        word       = cmd_pair(hdr.opcode, hdr.pack_en, hdr.pack_byte);
        word_drive = 1'b1;
      end
      PH_ADDR: begin
        word       = addr_pair(hdr.amode, hdr.addr);
        word_drive = 1'b1;
      end
      PH_DATA: begin
        word       = hdr.rd ? 16'h0000 : tx_word;
        word_drive = !hdr.rd;
        word_rx    = hdr.rd;
      end
      default: ;
    endcase
  end

  assign active = (phase == PH_CMD) || (phase == PH_ADDR) ||
                  (phase == PH_DUMMY) || (phase == PH_DATA);
endmodule

// File: rtl/onand_edge_capture.sv
module onand_edge_capture (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture_en,
  input  logic        ev_rise,
  input  logic        ev_fall,
  input  logic [7:0]  io_in,
  output logic [15:0] rx_word,
  output logic        rx_valid
);
  logic [7:0] rise_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_byte <= 8'h00;
      rx_word   <= 16'h0000;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (capture_en && ev_rise) rise_byte <= io_in;
      if (capture_en && ev_fall) begin
        rx_word  <= {rise_byte, io_in};
        rx_valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/onand_dtr_frame.sv
module onand_dtr_frame
  import onand_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int DUMMY_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [7:0]         opcode,
  input  logic               pack_en,
  input  logic [7:0]         pack_byte,
  input  logic [1:0]         addr_mode,
  input  logic [15:0]        addr,
  input  logic [DUMMY_W-1:0] dummy_slots,
  input  logic [LEN_W-1:0]   data_len,
  input  logic               rd,
  input  logic [15:0]        tx_word,
  output logic               tx_take,
  output logic [15:0]        rx_word,
  output logic               rx_valid,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               cs_n,
  output logic               sck,
  output logic [7:0]         io_out,
  output logic               io_oe,
  input  logic [7:0]         io_in
);
  onand_phase_e phase;
  onand_hdr_t   hdr_in;
  logic [15:0]  word;
  logic         word_drive, word_rx, active;
  logic         ev_load, ev_rise, ev_fall;
  logic         idle, odd_req, go;

  assign idle    = (phase == PH_IDLE);
  assign odd_req = data_len[0] | dummy_slots[0];
  assign go      = start && idle && !odd_req;
  assign busy    = !idle;
  assign cs_n    = idle;

  assign hdr_in = '{opcode:    opcode,
                    pack_en:   pack_en,
                    pack_byte: pack_byte,
                    amode:     onand_addr_e'(addr_mode),
                    addr:      addr,
                    rd:        rd};

  onand_word_seq #(.LEN_W(LEN_W), .DUMMY_W(DUMMY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .hdr_in(hdr_in),
    .dummy_in(dummy_slots), .len_in(data_len), .step(ev_fall),
    .tx_word(tx_word), .phase(phase), .word(word), .word_drive(word_drive),
    .word_rx(word_rx), .active(active), .done(done)
  );

  onand_dtr_lane u_lane (
    .clk(clk), .rst_n(rst_n), .active(active), .word(word),
    .word_drive(word_drive), .sck(sck), .io_out(io_out), .io_oe(io_oe),
    .ev_load(ev_load), .ev_rise(ev_rise), .ev_fall(ev_fall)
  );

  onand_edge_capture u_cap (
    .clk(clk), .rst_n(rst_n), .capture_en(word_rx), .ev_rise(ev_rise),
    .ev_fall(ev_fall), .io_in(io_in), .rx_word(rx_word), .rx_valid(rx_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err     <= 1'b0;
      tx_take <= 1'b0;
    end else begin
      err     <= start && idle && odd_req;
      tx_take <= ev_load && (phase == PH_DATA) && word_drive;
    end
  end
endmodule

// File: rtl/onand_dtr_frame_chk.sv
module onand_dtr_frame_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       cs_n,
  input logic       sck,
  input logic [7:0] io_out,
  input logic       io_oe,
  input logic       tx_take,
  input logic       rx_valid,
  input logic       done,
  input logic       err
);
  // R9
  stable_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sck != $past(sck)) |-> $stable(io_out));

  // R8
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R8
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);

  // R7
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> cs_n);

  // R5
  take_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> io_oe);

  // R6
  rx_listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !io_oe);

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !err);
endmodule

bind onand_dtr_frame onand_dtr_frame_chk u_chk (.*);

// File: tb/onand_dtr_frame_test.sv
module onand_dtr_frame_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 8;
  localparam int DUMMY_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic pack_en = 1'b0;
  logic [7:0] pack_byte = 8'h00;
  logic [1:0] addr_mode = 2'd0;
  logic [15:0] addr = 16'h0000;
  logic [DUMMY_W-1:0] dummy_slots = '0;
  logic [LEN_W-1:0] data_len = '0;
  logic rd = 1'b0;
  logic [15:0] tx_word = 16'h0000;
  logic [7:0] io_in = 8'h00;
  logic tx_take, rx_valid, busy, done, err, cs_n, sck, io_oe;
  logic [15:0] rx_word;
  logic [7:0] io_out;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  onand_dtr_frame #(.LEN_W(LEN_W), .DUMMY_W(DUMMY_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pack_en(pack_en),
    .pack_byte(pack_byte), .addr_mode(addr_mode), .addr(addr),
    .dummy_slots(dummy_slots), .data_len(data_len), .rd(rd), .tx_word(tx_word),
    .tx_take(tx_take), .rx_word(rx_word), .rx_valid(rx_valid), .busy(busy),
    .done(done), .err(err), .cs_n(cs_n), .sck(sck), .io_out(io_out),
    .io_oe(io_oe), .io_in(io_in)
  );

  function automatic logic [7:0] rx_b(input int e);
    return 8'((e * 37 + 5) & 255);
  endfunction

  function automatic logic [15:0] tx_w(input int s, input int j);
    return 16'((s * 1237 + j * 4099 + 17) & 16'hffff);
  endfunction

  task automatic chk(input string tag, input bit ok, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  logic [7:0] ev_b [64];
  bit         ev_oe[64];
  logic [7:0] ex_b [64];
  bit         ex_oe[64];
  string      ex_tag[64];
  logic [15:0] rx_got[32];

  task automatic push(inout int n, input bit oe, input logic [7:0] b, input string tag);
    ex_oe[n] = oe; ex_b[n] = b; ex_tag[n] = tag; n++;
  endtask

  task automatic run_frame(input int s, input int op, input int pk, input int pb,
                           input int am, input int ad, input int dm, input int ln,
                           input int r, input bit poke);
    int exn, evn, rxn, takes, dones, tidx;
    bit sck_q, seen_end;
    exn = 0;
    push(exn, 1'b1, 8'(op), "R1");
    push(exn, 1'b1, pk ? 8'(pb) : 8'(op), pk ? "R2" : "R1");
    if (am == 1) begin
      push(exn, 1'b1, 8'(ad >> 8), "R3"); push(exn, 1'b1, 8'(ad), "R3");
    end else if (am == 2) begin
      push(exn, 1'b1, 8'(ad), "R3"); push(exn, 1'b1, 8'(ad), "R3");
    end
    for (int k = 0; k < dm; k++) push(exn, 1'b0, 8'h00, "R4");
    for (int j = 0; j < ln / 2; j++) begin
      if (r != 0) begin
        push(exn, 1'b0, 8'h00, "R6"); push(exn, 1'b0, 8'h00, "R6");
      end else begin
        push(exn, 1'b1, tx_w(s, j) >> 8, "R5"); push(exn, 1'b1, 8'(tx_w(s, j)), "R5");
      end
    end

    @(negedge clk);
    opcode = 8'(op); pack_en = pk[0]; pack_byte = 8'(pb); addr_mode = 2'(am);
    addr = 16'(ad); dummy_slots = DUMMY_W'(dm); data_len = LEN_W'(ln); rd = r[0];
    tidx = 0; tx_word = tx_w(s, 0); io_in = rx_b(0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    evn = 0; rxn = 0; takes = 0; dones = 0; sck_q = 1'b0; seen_end = 1'b0;
    for (int it = 0; it < 400 && !seen_end; it++) begin
      @(negedge clk);
      if (sck != sck_q) begin
        if (evn < 64) begin ev_b[evn] = io_out; ev_oe[evn] = io_oe; end
        evn++;
        io_in = rx_b(evn);
      end
      sck_q = sck;
      if (tx_take) begin takes++; tidx++; tx_word = tx_w(s, tidx); end
      if (rx_valid) begin if (rxn < 32) rx_got[rxn] = rx_word; rxn++; end
      if (done) begin dones++; seen_end = 1'b1; end
      if (poke && it == 6) begin start = 1'b1; opcode = 8'(op) ^ 8'h5A; end
      if (poke && it == 7) start = 1'b0;
    end
    for (int it = 0; it < 3; it++) begin
      @(negedge clk);
      if (done) dones++;
    end
    chk("R8 sck edge count", evn == exn, evn, exn);
    for (int k = 0; k < exn && k < evn && k < 64; k++) begin
      chk({ex_tag[k], " drive"}, ev_oe[k] == ex_oe[k], int'(ev_oe[k]), int'(ex_oe[k]));
      if (ex_oe[k])
        chk({ex_tag[k], " byte"}, ev_b[k] == ex_b[k], int'(ev_b[k]), int'(ex_b[k]));
    end
    chk("R5 take count", takes == ((r == 0) ? ln / 2 : 0), takes, (r == 0) ? ln / 2 : 0);
    chk("R6 rx count", rxn == ((r != 0) ? ln / 2 : 0), rxn, (r != 0) ? ln / 2 : 0);
    if (r != 0) begin
      for (int j = 0; j < ln / 2 && j < rxn; j++) begin
        int d0;
        logic [15:0] w;
        d0 = exn - ln + 2 * j;
        w = {rx_b(d0), rx_b(d0 + 1)};
        chk("R6 rx word", rx_got[j] == w, rx_got[j], w);
      end
    end
    chk("R8 single done", dones == 1, dones, 1);
    chk("R8 released", cs_n == 1'b1 && sck == 1'b0, {cs_n, sck}, 2'b10);
    if (poke) begin
      chk("R10 cmd byte kept", evn > 0 && ev_b[0] == 8'(op), int'(ev_b[0]), op);
      chk("R10 no extra frame", dones == 1 && cs_n, dones, 1);
    end
  endtask

  task automatic reject(input int dm, input int ln);
    int errs;
    bit active_seen;
    @(negedge clk);
    dummy_slots = DUMMY_W'(dm); data_len = LEN_W'(ln); rd = 1'b0;
    start = 1'b1;
    errs = 0; active_seen = 1'b0;
    for (int it = 0; it < 12; it++) begin
      @(negedge clk);
      start = 1'b0;
      if (err) errs++;
      if (!cs_n || sck) active_seen = 1'b1;
    end
    chk("R7 err pulse", errs == 1, errs, 1);
    chk("R7 no frame", !active_seen, int'(active_seen), 0);
  endtask

  initial begin
    int wd;
    for (wd = 0; wd < 150000; wd++) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int s;
    int dms[3];
    dms[0] = 0; dms[1] = 2; dms[2] = 14;
    repeat (3) @(negedge clk);
    chk("R8 reset idle", cs_n == 1'b1 && sck == 1'b0 && io_oe == 1'b0 && !busy,
        {cs_n, sck, io_oe, busy}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle after reset", cs_n && !sck && !done && !err, {cs_n, sck, done, err}, 4'b1000);

    // Feature read: register byte repeated, 14 dummy slots, two data bytes.
    run_frame(900, 8'h0F, 0, 0, 2, 16'h00C0, 14, 2, 1, 1'b0);
    // Packed page read: top row byte in the second command slot.
    run_frame(901, 8'h13, 1, 8'h2B, 1, 16'h4C71, 0, 0, 0, 1'b0);
    // Command-only frame.
    run_frame(902, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 1'b0);

    s = 0;
    for (int am = 0; am < 3; am++)
      for (int pk = 0; pk < 2; pk++)
        for (int di = 0; di < 3; di++)
          for (int li = 0; li < 4; li++)
            for (int r = 0; r < 2; r++) begin
              run_frame(s, (s * 29 + 3) & 255, pk, (s * 53 + 11) & 255, am,
                        (s * 2749 + 301) & 16'hffff, dms[di], 2 * li, r, (s % 7) == 3);
              s++;
            end

    reject(0, 3);
    reject(3, 2);
    reject(5, 5);
    run_frame(950, 8'hC4, 0, 0, 1, 16'h0123, 0, 6, 0, 1'b0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule